// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets bus write cycles aimed at a parallel NOR-style flash model. Each write carries an address and a 16-bit data word; the command code is taken from data bits [7:0]. One-cycle commands act at once, while two-cycle commands first enter a setup state and then expect a confirm code on the next write. The decoder keeps a lock and lock-down bit for every block, builds an 8-bit status word, holds a read configuration word, latches the address and data of a one-time-register program, counts the data words of an extended buffered sequence, and runs a cycle timer that stands in for the embedded program, erase and blank-check algorithms. A running program or erase may be suspended and later resumed.

The block index is the top `BLK_W` bits of the write address. Status bits: 7 ready, 6 erase suspended, 5 erase/sequence error, 4 program/sequence error, 2 program suspended, 1 locked-block error; bits 3 and 0 read 0. States: `S_READY` (idle, takes single-cycle codes and setup codes), `S_LOCK_SETUP` (after 0x60), `S_PROG_SETUP` (after 0x40 or 0x10), `S_ERASE_SETUP` (after 0x20), `S_BLANK_SETUP` (after 0xBC), `S_OTP_SETUP` (after 0xC0), `S_EXT_SUBOP`, `S_EXT_COUNT`, `S_EXT_DATA` (after 0xEB), `S_BUSY` (timer running) and `S_SUSP` (operation held). Transitions: every setup state returns to `S_READY` on an error or a completed one-cycle action and moves to `S_BUSY` when an operation starts; `S_BUSY` goes to `S_READY` when the timer expires or to `S_SUSP` on 0xB0 for a program or erase; `S_SUSP` goes back to `S_BUSY` on 0xD0; the extended states advance on each write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An active-low asynchronous reset gives status 0x80, read-array mode (`rd_array`=1), every block locked, no block locked down, `rcr` equal to `RCR_RST`, and aborts any running or suspended operation.
- R2: After 0x60, a second write of 0x01 locks, 0xD0 unlocks and 0x2F locks down (lock-down also locks) the block selected by the second write's address.
- R3: An unlock aimed at a locked-down block leaves both its bits unchanged and sets no error.
- R4: A second write after 0x60, 0x20 or 0xBC that is not a valid code for that setup sets status bits 5 and 4; error bits 5, 4 and 1 stay set until 0x50 is written in `S_READY`.
- R5: 0x03 after 0x60 loads address bits [16:1] into `rcr` and selects read-array mode; 0x70 and every operation setup code select status mode, 0xFF selects array mode.
- R6: A program (0x40 or 0x10, then a data write) holds status bit 7 low for exactly `PROG_CYC` cycles after the data write; an erase (0x20 then 0xD0) for `ERASE_CYC` cycles.
- R7: A program or extended sequence on a locked block sets status bits 4 and 1; an erase on a locked block sets bits 5 and 1; neither starts the timer.
- R8: 0xB0 during a program gives status bits 7 and 2, during an erase bits 7 and 6; the timer stays frozen and every write other than 0xD0 is ignored while suspended.
- R9: 0xD0 while suspended clears bit 7 again and the operation finishes after exactly the cycles it still had when suspended.
- R10: Blank check (0xBC then 0xD0) keeps bit 7 low for `BLANK_CYC` cycles and ignores 0xB0.
- R11: 0xC0 followed by any write latches that write's address on `otp_addr` and data on `otp_data` and runs the timer for `PROG_CYC` cycles.
- R12: 0xEB, a sub-opcode write, then a count write n (0 to 511) accept n+1 data writes with status still 0x80, and the last one starts a `PROG_CYC` program on the block addressed by the 0xEB write; a count above 511 sets bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; top BLK_W bits select the block |
| wr_data | input | 16 | Write data; bits [7:0] hold the command code |
| status | output | 8 | Status word |
| rd_array | output | 1 | 1 when reads return array data, 0 when they return status |
| rcr | output | 16 | Read configuration word |
| blk_locked | output | 2**BLK_W | Lock bit per block |
| blk_lockdown | output | 2**BLK_W | Lock-down bit per block |
| otp_addr | output | ADDR_W | Address latched by the one-time-register program |
| otp_data | output | 16 | Data latched by the one-time-register program |

## Verification
Lock bits, error bits, `rcr`, `otp_*` and the read mode change at the clock edge that captures the write, so the bench samples them at the falling edge right after it. The timer loads at the edge of the starting write and status bit 7 returns high N edges later; the bench samples at edge N-1 (still busy) and at edge N (ready). For a suspend after a edges the remaining count is N-(a+1), counted from the edge of the resume write, and the bench checks both sides of that edge too.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        S_READY, S_LOCK_SETUP, S_PROG_SETUP, S_ERASE_SETUP, S_BLANK_SETUP,
        S_OTP_SETUP, S_EXT_SUBOP, S_EXT_COUNT, S_EXT_DATA, S_BUSY, S_SUSP
    } fcd_state_e;

    typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_BLANK, OP_OTP} fcd_op_e;

    typedef enum logic [1:0] {LK_NONE, LK_LOCK, LK_UNLOCK, LK_DOWN} fcd_lk_e;

    localparam logic [7:0] CMD_LK_SETUP = 8'h60;
    localparam logic [7:0] CMD_LOCK     = 8'h01;
    localparam logic [7:0] CMD_LOCKDOWN = 8'h2F;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_RCR      = 8'h03;
    localparam logic [7:0] CMD_PROG     = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_BLANK    = 8'hBC;
    localparam logic [7:0] CMD_OTP      = 8'hC0;
    localparam logic [7:0] CMD_EXT      = 8'hEB;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_CLR      = 8'h50;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;

    localparam logic [15:0] EXT_MAX_CNT = 16'd511;

endpackage

// File: rtl/fcd_lock_table.sv
module fcd_lock_table
    import fcd_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fcd_lk_e          lk_op,
    input  logic [BLK_W-1:0] lk_blk,
    output logic [(1<<BLK_W)-1:0] locked,
    output logic [(1<<BLK_W)-1:0] lockdown
);
    localparam int NBLK = 1 << BLK_W;

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic hit;
        assign hit = (lk_blk == BLK_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                locked[i]   <= 1'b1;
                lockdown[i] <= 1'b0;
            end else if (hit) begin
                unique case (lk_op)
                    LK_LOCK:   locked[i] <= 1'b1;
                    LK_UNLOCK: if (!lockdown[i]) locked[i] <= 1'b0;
                    LK_DOWN: begin
                        locked[i]   <= 1'b1;
                        lockdown[i] <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        // R3: once locked down, a block stays locked and locked down until reset
        a_r3_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            lockdown[i] |=> (lockdown[i] && locked[i]));
    end

endmodule

// File: rtl/fcd_op_timer.sv
module fcd_op_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             pause,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= load;
        else if (cnt_q != '0 && !pause)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1)) && !pause;

    // R8: a paused timer keeps its remaining count
    a_r8_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !start) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          BLK_W     = 3,
    parameter int          PROG_CYC  = 10,
    parameter int          ERASE_CYC = 24,
    parameter int          BLANK_CYC = 6,
    parameter logic [15:0] RCR_RST   = 16'hBFCF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [15:0]              wr_data,
    output logic [7:0]               status,
    output logic                     rd_array,
    output logic [15:0]              rcr,
    output logic [(1<<BLK_W)-1:0]    blk_locked,
    output logic [(1<<BLK_W)-1:0]    blk_lockdown,
    output logic [ADDR_W-1:0]        otp_addr,
    output logic [15:0]              otp_data
);
    localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_PE > BLANK_CYC) ? MAX_PE : BLANK_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fcd_state_e       state_q, state_d;
    fcd_op_e          op_q, op_d;
    fcd_lk_e          lk_op;
    logic [7:0]       code;
    logic [BLK_W-1:0] blk_idx;
    logic [BLK_W-1:0] ext_blk_q;
    logic [8:0]       ext_left_q;
    logic             sr1_q, sr4_q, sr5_q;
    logic             set1, set4, set5, clr_err;
    logic             to_array, to_status, ld_rcr, ld_otp;
    logic             ext_blk_ld, ext_cnt_ld, ext_dec, op_ld;
    logic             tmr_start, tmr_busy, tmr_done;
    logic [CNT_W-1:0] tmr_load;

    assign code    = wr_data[7:0];
    assign blk_idx = wr_addr[ADDR_W-1 -: BLK_W];

    fcd_lock_table #(.BLK_W(BLK_W)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_op    (lk_op),
        .lk_blk   (blk_idx),
        .locked   (blk_locked),
        .lockdown (blk_lockdown)
    );

    fcd_op_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .load  (tmr_load),
        .pause (state_q == S_SUSP),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_READY;
        else        state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d    = state_q;
        op_d       = op_q;
        op_ld      = 1'b0;
        lk_op      = LK_NONE;
        set1       = 1'b0;
        set4       = 1'b0;
        set5       = 1'b0;
        clr_err    = 1'b0;
        to_array   = 1'b0;
        to_status  = 1'b0;
        ld_rcr     = 1'b0;
        ld_otp     = 1'b0;
        ext_blk_ld = 1'b0;
        ext_cnt_ld = 1'b0;
        ext_dec    = 1'b0;
        tmr_start  = 1'b0;
        tmr_load   = '0;
        unique case (state_q)
            S_READY: if (wr_en) begin
                case (code)
                    CMD_LK_SETUP: state_d = S_LOCK_SETUP;
                    CMD_PROG, CMD_PROG_ALT: begin
                        state_d = S_PROG_SETUP; to_status = 1'b1;
                    end
                    CMD_ERASE: begin
                        state_d = S_ERASE_SETUP; to_status = 1'b1;
                    end
                    CMD_BLANK: begin
                        state_d = S_BLANK_SETUP; to_status = 1'b1;
                    end
                    CMD_OTP: begin
                        state_d = S_OTP_SETUP; to_status = 1'b1;
                    end
                    CMD_EXT: begin
                        state_d = S_EXT_SUBOP; to_status = 1'b1; ext_blk_ld = 1'b1;
                    end
                    CMD_CLR:      clr_err   = 1'b1;
                    CMD_RD_STAT:  to_status = 1'b1;
                    CMD_RD_ARRAY: to_array  = 1'b1;
                    default: ;
                endcase
            end
            S_LOCK_SETUP: if (wr_en) begin
                state_d = S_READY;
                case (code)
                    CMD_LOCK:     lk_op = LK_LOCK;
                    CMD_CONFIRM:  lk_op = LK_UNLOCK;
                    CMD_LOCKDOWN: lk_op = LK_DOWN;
                    CMD_RCR: begin
                        ld_rcr = 1'b1; to_array = 1'b1;
                    end
                    default: begin
                        set4 = 1'b1; set5 = 1'b1;
                    end
                endcase
            end
            S_PROG_SETUP: if (wr_en) begin
                if (blk_locked[blk_idx]) begin
                    state_d = S_READY; set4 = 1'b1; set1 = 1'b1;
                end else begin
                    state_d = S_BUSY; tmr_start = 1'b1; tmr_load = CNT_W'(PROG_CYC);
                    op_d = OP_PROG; op_ld = 1'b1;
                end
            end
            S_ERASE_SETUP: if (wr_en) begin
                if (code != CMD_CONFIRM) begin
                    state_d = S_READY; set4 = 1'b1; set5 = 1'b1;
                end else if (blk_locked[blk_idx]) begin
                    state_d = S_READY; set5 = 1'b1; set1 = 1'b1;
                end else begin
                    state_d = S_BUSY; tmr_start = 1'b1; tmr_load = CNT_W'(ERASE_CYC);
                    op_d = OP_ERASE; op_ld = 1'b1;
                end
            end
            S_BLANK_SETUP: if (wr_en) begin
                if (code != CMD_CONFIRM) begin
                    state_d = S_READY; set4 = 1'b1; set5 = 1'b1;
                end else begin
                    state_d = S_BUSY; tmr_start = 1'b1; tmr_load = CNT_W'(BLANK_CYC);
                    op_d = OP_BLANK; op_ld = 1'b1;
                end
            end
            S_OTP_SETUP: if (wr_en) begin
                state_d = S_BUSY; ld_otp = 1'b1;
                tmr_start = 1'b1; tmr_load = CNT_W'(PROG_CYC);
                op_d = OP_OTP; op_ld = 1'b1;
            end
            S_EXT_SUBOP: if (wr_en) state_d = S_EXT_COUNT;
            S_EXT_COUNT: if (wr_en) begin
                if (wr_data > EXT_MAX_CNT) begin
                    state_d = S_READY; set4 = 1'b1; set5 = 1'b1;
                end else begin
                    state_d = S_EXT_DATA; ext_cnt_ld = 1'b1;
                end
            end
            S_EXT_DATA: if (wr_en) begin
                if (ext_left_q != '0) begin
                    ext_dec = 1'b1;
                end else if (blk_locked[ext_blk_q]) begin
                    state_d = S_READY; set4 = 1'b1; set1 = 1'b1;
                end else begin
                    state_d = S_BUSY; tmr_start = 1'b1; tmr_load = CNT_W'(PROG_CYC);
                    op_d = OP_PROG; op_ld = 1'b1;
                end
            end
            S_BUSY: begin
                if (tmr_done)
                    state_d = S_READY;
                else if (wr_en && code == CMD_SUSPEND &&
                         (op_q == OP_PROG || op_q == OP_ERASE))
                    state_d = S_SUSP;
            end
            S_SUSP: if (wr_en && code == CMD_CONFIRM) state_d = S_BUSY;
            default: state_d = S_READY;
        endcase
    end

    // registered outputs and sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_PROG;
            sr1_q      <= 1'b0;
            sr4_q      <= 1'b0;
            sr5_q      <= 1'b0;
            rd_array   <= 1'b1;
            rcr        <= RCR_RST;
            otp_addr   <= '0;
            otp_data   <= '0;
            ext_blk_q  <= '0;
            ext_left_q <= '0;
        end else begin
            if (op_ld) op_q <= op_d;
            sr1_q <= (sr1_q & ~clr_err) | set1;
            sr4_q <= (sr4_q & ~clr_err) | set4;
            sr5_q <= (sr5_q & ~clr_err) | set5;
            if (to_array)       rd_array <= 1'b1;
            else if (to_status) rd_array <= 1'b0;
            if (ld_rcr) rcr <= wr_addr[16:1];
            if (ld_otp) begin
                otp_addr <= wr_addr;
                otp_data <= wr_data;
            end
            if (ext_blk_ld) ext_blk_q <= blk_idx;
            if (ext_cnt_ld)   ext_left_q <= wr_data[8:0];
            else if (ext_dec) ext_left_q <= ext_left_q - 1'b1;
        end
    end

    assign status = {state_q != S_BUSY,
                     state_q == S_SUSP && op_q == OP_ERASE,
                     sr5_q, sr4_q, 1'b0,
                     state_q == S_SUSP && op_q == OP_PROG,
                     sr1_q, 1'b0};

    // R6: the busy state always has a running timer behind it
    a_r6_busy_has_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY) |-> tmr_busy);

    // R4: error bits hold until a clear command in the ready state
    a_r4_err4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sr4_q && !(state_q == S_READY && wr_en && code == CMD_CLR)) |=> sr4_q);

    a_r4_err5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sr5_q && !(state_q == S_READY && wr_en && code == CMD_CLR)) |=> sr5_q);

    // R9: a confirm write while suspended resumes the operation
    a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SUSP && wr_en && code == CMD_CONFIRM) |=> (status[7] == 1'b0));

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int ADDR_W = 20;
    localparam int BLK_W  = 3;
    localparam int PROG   = 10;
    localparam int ERASE  = 24;
    localparam int BLANK  = 6;
    localparam logic [15:0] RCR0 = 16'hBFCF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [7:0]        status;
    logic              rd_array;
    logic [15:0]       rcr;
    logic [7:0]        blk_locked, blk_lockdown;
    logic [ADDR_W-1:0] otp_addr;
    logic [15:0]       otp_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG), .ERASE_CYC(ERASE),
        .BLANK_CYC(BLANK), .RCR_RST(RCR0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status(status), .rd_array(rd_array), .rcr(rcr), .blk_locked(blk_locked),
        .blk_lockdown(blk_lockdown), .otp_addr(otp_addr), .otp_data(otp_data)
    );

    function automatic logic [ADDR_W-1:0] blk(input int b);
        return ADDR_W'(b) << (ADDR_W - BLK_W);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic t_reset_state();
        chk("R1", "status", status, 8'h80);
        chk("R1", "rd_array", rd_array, 1);
        chk("R1", "locked", blk_locked, 8'hFF);
        chk("R1", "lockdown", blk_lockdown, 8'h00);
        chk("R1", "rcr", rcr, RCR0);
    endtask

    task automatic t_lock();
        wr(blk(2), 16'h60); wr(blk(2), 16'hD0);
        chk("R2", "unlock blk2", blk_locked, 8'hFB);
        wr(blk(2), 16'h60); wr(blk(2), 16'h01);
        chk("R2", "relock blk2", blk_locked, 8'hFF);
        wr(blk(4), 16'h60); wr(blk(4), 16'h2F);
        chk("R2", "lockdown blk4", blk_lockdown, 8'h10);
        wr(blk(4), 16'h60); wr(blk(4), 16'hD0);
        chk("R3", "unlock on lockdown locked", blk_locked, 8'hFF);
        chk("R3", "unlock on lockdown ld", blk_lockdown, 8'h10);
        chk("R3", "no error", status, 8'h80);
    endtask

    task automatic t_seq_err();
        wr(0, 16'h60); wr(0, 16'h77);
        chk("R4", "bad lock confirm", status, 8'hB0);
        wr(0, 16'hFF);
        chk("R4", "error sticky", status, 8'hB0);
        wr(0, 16'h50);
        chk("R4", "clear", status, 8'h80);
        wr(0, 16'h20); wr(0, 16'h33);
        chk("R4", "bad erase confirm", status, 8'hB0);
        wr(0, 16'h50);
        wr(0, 16'hBC); wr(0, 16'h12);
        chk("R4", "bad blank confirm", status, 8'hB0);
        wr(0, 16'h50);
        chk("R4", "clear again", status, 8'h80);
    endtask

    task automatic t_rcr();
        wr(0, 16'h70);
        chk("R5", "status mode", rd_array, 0);
        wr(0, 16'h60); wr(20'h02468, 16'h03);
        chk("R5", "rcr load", rcr, 16'h1234);
        chk("R5", "array mode", rd_array, 1);
    endtask

    task automatic t_prog();
        wr(blk(0), 16'h60); wr(blk(0), 16'hD0);
        wr(20'h00100, 16'h40);
        chk("R5", "prog setup status mode", rd_array, 0);
        wr(20'h00100, 16'hABCD);
        wait_cyc(PROG - 1);
        chk("R6", "prog busy last cycle", status, 8'h00);
        wait_cyc(1);
        chk("R6", "prog done", status, 8'h80);
    endtask

    task automatic t_locked_ops();
        wr(blk(6), 16'h40); wr(blk(6), 16'h1234);
        chk("R7", "prog locked", status, 8'h92);
        wr(0, 16'h50);
        wr(blk(6), 16'h20); wr(blk(6), 16'hD0);
        chk("R7", "erase locked", status, 8'hA2);
        wr(0, 16'h50);
    endtask

    task automatic t_susp_prog();
        wr(0, 16'h40); wr(0, 16'h5555);
        wait_cyc(3);
        wr(0, 16'hB0);
        chk("R8", "prog suspended", status, 8'h84);
        wait_cyc(20);
        chk("R8", "prog held", status, 8'h84);
        wr(0, 16'hD0);
        chk("R9", "prog resumed", status, 8'h00);
        wait_cyc(PROG - 4 - 1);
        chk("R9", "prog remaining busy", status, 8'h00);
        wait_cyc(1);
        chk("R9", "prog remaining done", status, 8'h80);
    endtask

    task automatic t_susp_erase();
        wr(blk(1), 16'h60); wr(blk(1), 16'hD0);
        wr(blk(1), 16'h20); wr(blk(1), 16'hD0);
        wait_cyc(2);
        wr(blk(1), 16'hB0);
        chk("R8", "erase suspended", status, 8'hC0);
        wr(blk(2), 16'h60); wr(blk(2), 16'h2F);
        chk("R8", "lock cmd ignored", blk_lockdown, 8'h10);
        chk("R8", "still suspended", status, 8'hC0);
        wr(blk(1), 16'hD0);
        chk("R9", "erase resumed", status, 8'h00);
        wait_cyc(ERASE - 3 - 1);
        chk("R9", "erase remaining busy", status, 8'h00);
        wait_cyc(1);
        chk("R9", "erase remaining done", status, 8'h80);
    endtask

    task automatic t_blank();
        wr(blk(6), 16'hBC); wr(blk(6), 16'hD0);
        chk("R10", "blank busy", status, 8'h00);
        wait_cyc(1);
        wr(0, 16'hB0);
        chk("R10", "suspend ignored", status, 8'h00);
        wait_cyc(BLANK - 3);
        chk("R10", "blank busy last", status, 8'h00);
        wait_cyc(1);
        chk("R10", "blank done", status, 8'h80);
    endtask

    task automatic t_otp();
        wr(0, 16'hC0); wr(20'h12345, 16'hBEEF);
        chk("R11", "otp addr", otp_addr, 20'h12345);
        chk("R11", "otp data", otp_data, 16'hBEEF);
        chk("R11", "otp busy", status, 8'h00);
        wait_cyc(PROG - 1);
        chk("R11", "otp busy last", status, 8'h00);
        wait_cyc(1);
        chk("R11", "otp done", status, 8'h80);
    endtask

    task automatic t_ext();
        wr(blk(3), 16'h60); wr(blk(3), 16'hD0);
        wr(blk(3), 16'hEB); wr(blk(3), 16'h0000); wr(blk(3), 16'd2);
        wr(blk(3), 16'h1111);
        chk("R12", "word 1 ready", status, 8'h80);
        wr(blk(3), 16'h2222);
        chk("R12", "word 2 ready", status, 8'h80);
        wr(blk(3), 16'h3333);
        chk("R12", "last word starts", status, 8'h00);
        wait_cyc(PROG - 1);
        chk("R12", "ext busy last", status, 8'h00);
        wait_cyc(1);
        chk("R12", "ext done", status, 8'h80);
        wr(0, 16'hEB); wr(0, 16'h0000); wr(0, 16'd512);
        chk("R12", "count too big", status, 8'hB0);
        wr(0, 16'h50);
        wr(blk(5), 16'hEB); wr(blk(5), 16'h0000); wr(blk(5), 16'd0);
        wr(blk(5), 16'h4444);
        chk("R7", "ext on locked block", status, 8'h92);
        wr(0, 16'h50);
    endtask

    task automatic t_reset_mid();
        wr(blk(1), 16'h20); wr(blk(1), 16'hD0);
        wait_cyc(2);
        chk("R6", "erase running", status, 8'h00);
        do_reset();
        chk("R1", "status after abort", status, 8'h80);
        chk("R1", "locked after abort", blk_locked, 8'hFF);
        chk("R1", "lockdown after abort", blk_lockdown, 8'h00);
        chk("R1", "array after abort", rd_array, 1);
        chk("R1", "rcr after abort", rcr, RCR0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_reset_state();
        t_lock();
        t_seq_err();
        t_rcr();
        t_prog();
        t_locked_ops();
        t_susp_prog();
        t_susp_erase();
        t_blank();
        t_otp();
        t_ext();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule